// File: doc/BRIEF.md
# Serial Run Length Monitor

This block sits behind a clock recovery stage and watches the recovered bit stream. A bit is taken in only on cycles where its valid strobe is high. The block counts how many equal bits, ones or zeros, have arrived back to back. When the unbroken run grows longer than a 6-bit programmable limit, it raises a violation level. Core logic can watch this level, or it can be routed to an output pin, to detect a line that has stopped toggling. Without transitions the upstream phase tracking has nothing to lock to.

The limit is meant to hold a value from 1 to 62. A value of zero turns the check off. The all-ones code is clamped to 62. The flag follows the current run: it stays high while the offending run goes on and drops on the first differing valid bit. The run counter saturates, so an arbitrarily long run can never wrap around and clear the flag.

Top module: `run_limit_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears the run count and drives `violation` low. Input bits presented during reset are ignored. The first valid bit after reset starts a run of length 1.
- R2: A bit is taken only on a rising clock edge where `bit_vld` is 1. Cycles with `bit_vld` at 0 leave the run count unchanged, whatever `bit_in` carries.
- R3: A valid bit that differs from the previous valid bit restarts the run at 1. `violation` is low after that edge for any limit.
- R4: `violation` is 1 exactly when the current run length is strictly greater than the effective limit. A run equal to the limit does not flag. The flag reflects a new bit right after the clock edge that accepts it.
- R5: A limit of 0 disables checking: `violation` stays 0 for a run of any length.
- R6: A limit of 63 acts as 62: a run of 62 does not flag and a run of 63 does.
- R7: The run count saturates at 63. A run of any length beyond the limit keeps `violation` at 1 until a differing valid bit arrives.
- R8: `violation` is a level that follows `run_limit` with no clock edge needed. Raising the limit above the current run clears the flag at once, and lowering it below the run sets the flag at once.
- R9: Runs of ones and runs of zeros are treated alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Recovered serial bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| run_limit | input | 6 | Maximum allowed run length; 0 disables, 63 acts as 62 |
| violation | output | 1 | High while the current run exceeds the limit |

## Verification
The only internal state is the run count and the previous bit. Either one being wrong shows on `violation` at the limit boundary. A count that is one too high or too low makes the flag rise one accepted bit early or late. A stale previous bit makes the flag fail to drop on the first differing bit. The bench therefore walks runs across each limit value, bit by bit, and samples the flag in the same cycle as each accepted bit, so any such error shows within one bit. A counter that wraps shows only after 64 equal bits, so runs of well over 64 are driven on purpose.

// File: rtl/run_limit_monitor.sv
module run_limit_monitor #(
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic [LIM_W-1:0] run_limit,
  output logic             violation
);

  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};
  localparam logic [LIM_W-1:0] LIM_TOP = CNT_MAX - 1'b1;

  logic [LIM_W-1:0] cnt;
  logic             last_bit;
  logic [LIM_W-1:0] lim_eff;
  logic             same;

  assign lim_eff   = (run_limit == CNT_MAX) ? LIM_TOP : run_limit;
  assign same      = (cnt != '0) && (bit_in == last_bit);
  assign violation = (lim_eff != '0) && (cnt > lim_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      last_bit <= 1'b0;
    end else if (bit_vld) begin
      last_bit <= bit_in;
      if (!same)
        cnt <= {{(LIM_W-1){1'b0}}, 1'b1};
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !violation);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cnt) && $stable(last_bit));

  a_r2_grow: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && cnt != '0 && bit_in == last_bit && cnt != CNT_MAX)
      |=> cnt == $past(cnt) + 1'b1);

  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && cnt != '0 && bit_in != last_bit)
      |=> (cnt == 1) && !violation);

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && cnt == CNT_MAX && bit_in == last_bit) |=> cnt == CNT_MAX);

  a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
    (run_limit == '0) |-> !violation);

endmodule

// File: tb/run_limit_monitor_test.sv
`timescale 1ns/1ps
module run_limit_monitor_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_in = 1'b0;
  logic       bit_vld = 1'b0;
  logic [5:0] run_limit = 6'd0;
  logic       violation;

  int tests = 0;
  int fails = 0;
  int exp_cnt = 0;
  logic exp_last = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  run_limit_monitor uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .run_limit(run_limit), .violation(violation)
  );

  function automatic int eff_lim(input logic [5:0] l);
    return (l == 6'd63) ? 62 : int'(l);
  endfunction

  function automatic logic exp_flag(input int c, input logic [5:0] l);
    return (eff_lim(l) != 0) && (c > eff_lim(l));
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: violation=%0b expected=%0b (run=%0d limit=%0d)",
               tag, act, exp, exp_cnt, run_limit);
    end
  endtask

  task automatic send(input logic v, input logic b, input string tag);
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    @(posedge clk);
    if (v) begin
      if (exp_cnt == 0 || b != exp_last) exp_cnt = 1;
      else if (exp_cnt < 63) exp_cnt++;
      exp_last = b;
    end
    #1;
    chk(tag, violation, exp_flag(exp_cnt, run_limit));
  endtask

  task automatic run(input int n, input logic b, input string tag);
    for (int i = 0; i < n; i++) send(1'b1, b, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_vld = 1'b1;
    bit_in = 1'b1;
    @(posedge clk);
    exp_cnt = 0;
    #1;
    chk("R1 reset", violation, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    bit_vld = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    run_limit = 6'd1;
    do_reset();
    send(1'b1, 1'b0, "R1 first bit run of one");
    send(1'b1, 1'b0, "R4 run 2 over limit 1");
    send(1'b1, 1'b1, "R3 change drops flag");

    run_limit = 6'd5;
    run(4, 1'b0, "R3/R9 zeros below limit");
    send(1'b1, 1'b1, "R3 restart");
    run(4, 1'b1, "R4 ones up to limit");
    send(1'b0, 1'b0, "R2 invalid cycle ignored");
    send(1'b0, 1'b1, "R2 invalid cycle ignored");
    send(1'b1, 1'b1, "R4 run 6 over limit 5");
    send(1'b0, 1'b0, "R2 gap keeps flag");
    send(1'b1, 1'b1, "R4 still over");
    #0.5; run_limit = 6'd20; #0.5;
    chk("R8 raise limit clears", violation, 1'b0);
    run_limit = 6'd3; #0.5;
    chk("R8 lower limit sets", violation, 1'b1);
    send(1'b1, 1'b0, "R3 change drops flag");

    run_limit = 6'd0;
    run(80, 1'b1, "R5 disabled long run");

    run_limit = 6'd63;
    send(1'b1, 1'b0, "R6 restart");
    run(61, 1'b0, "R6 below 62");
    send(1'b1, 1'b0, "R6 run 63 flags with limit 63");

    run_limit = 6'd62;
    run(100, 1'b0, "R7 saturated run keeps flag");
    send(1'b1, 1'b1, "R7 change clears after saturation");

    run_limit = 6'd2;
    do_reset();
    send(1'b1, 1'b1, "R1 first bit after reset");
    send(1'b1, 1'b1, "R1 run 2 equals limit");
    send(1'b1, 1'b1, "R4 run 3 flags");

    begin
      logic prev = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        logic v, b;
        if ($urandom % 40 == 0) run_limit = 6'($urandom % 64);
        v = ($urandom % 4) != 0;
        b = (($urandom % 10) == 0) ? ~prev : prev;
        if (v) prev = b;
        send(v, b, "R4 random");
      end
    end

    done = 1;
    report();
  end

endmodule